// File: doc/BRIEF.md
# Trip-Use Count Bypass Predictor

This block sits beside an exclusive last-level cache and decides, for every line the L2 evicts, whether the line should be written into the LLC or dropped on the floor. Each evicting line carries two small history fields. The first is a one-bit trip flag that says whether the line has ever come back to the L2 from the LLC. The second is a two-bit count of demand hits the line received while in the L2. Together the two fields name one of eight bins.

For each bin the block keeps a live tally and a dead tally. The LLC stores the bin number with every line it allocates and sends it back later on one of two strobes. A hit strobe means the allocation was useful, so it counts as live. An eviction of a line that was never hit counts as dead. A new eviction request is answered one cycle later with allocate or bypass. Bypass is returned only when the request's bin currently shows more dead allocations than live ones.

Tallies are kept in saturating counters. When either counter of a bin fills up, both counters of that bin are halved, which keeps the dead-to-live ratio while letting the history age.

Top module: `tuc_bypass_predictor`

## Requirements
- R1: The bin of a request is `{req_trip, req_use}`, with the trip flag as bit 2 and the use count as bits 1:0. `dec_bin` returns that bin with the decision.
- R2: A pulse on `live_valid` adds one to the live tally of bin `live_bin`.
- R3: A pulse on `dead_valid` adds one to the dead tally of bin `dead_bin`.
- R4: `dec_bypass` is 1 only when the bin's dead tally is strictly greater than its live tally. A tie, including both tallies at zero, gives allocate (`dec_bypass` = 0).
- R5: `dec_valid` is high in exactly the cycle after a cycle with `req_valid` high, and low in every other cycle.
- R6: Training strobes that arrive in the same cycle as a request are counted before that request's comparison is made.
- R7: Tallies are CNT_W bits wide (8 by default). When an increment would bring either tally of a bin to 2^CNT_W-1, both tallies of that bin are stored halved, rounding down, after the increment.
- R8: Training one bin never changes the decisions given for any other bin.
- R9: Synchronous active-high reset clears every tally to zero and holds `dec_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | An L2 eviction asks for a decision |
| req_trip | input | 1 | Trip flag of the evicting line |
| req_use | input | 2 | L2 demand-hit count of the evicting line |
| live_valid | input | 1 | An LLC hit on an allocated line |
| live_bin | input | 3 | Bin stored with the line that was hit |
| dead_valid | input | 1 | An LLC eviction of a line that was never hit |
| dead_bin | input | 3 | Bin stored with the evicted line |
| dec_valid | output | 1 | Decision is valid |
| dec_bypass | output | 1 | 1 = bypass the LLC, 0 = allocate |
| dec_bin | output | 3 | Bin of the decided request |

## Verification
The tallies can only be seen through the decisions, so any fault in them shows up as a flipped `dec_bypass` the next time that bin is asked for a decision, one cycle after the request. A counter that drifts by one is caught by sweeps that keep the dead-minus-live difference near zero, where a single count flips the answer. A missing or wrong halving only changes the ratio after saturation, so one bin is driven into saturation and then brought back to an exact tie. Bins that were left untouched are checked at the same time to catch any leak between bins.

// File: rtl/tuc_pkg.sv
package tuc_pkg;
  localparam int TRIP_W   = 1;
  localparam int USE_W    = 2;
  localparam int BIN_W    = TRIP_W + USE_W;
  localparam int NUM_BINS = 1 << BIN_W;

  typedef logic [BIN_W-1:0] bin_t;
endpackage

// File: rtl/tuc_bin_counter.sv
module tuc_bin_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             live_inc,
  input  logic             dead_inc,
  output logic [CNT_W-1:0] live_nx,
  output logic [CNT_W-1:0] dead_nx,
  output logic [CNT_W-1:0] live_q,
  output logic [CNT_W-1:0] dead_q
);
  localparam logic [CNT_W:0]   SAT_W1 = {1'b0, {CNT_W{1'b1}}};
  localparam logic [CNT_W-1:0] SAT    = {CNT_W{1'b1}};

  logic [CNT_W:0] l_sum, d_sum;
  logic           sat;

  always_comb begin
    l_sum   = {1'b0, live_q} + {{CNT_W{1'b0}}, live_inc};
    d_sum   = {1'b0, dead_q} + {{CNT_W{1'b0}}, dead_inc};
    sat     = (l_sum >= SAT_W1) || (d_sum >= SAT_W1);
    live_nx = sat ? l_sum[CNT_W:1] : l_sum[CNT_W-1:0];
    dead_nx = sat ? d_sum[CNT_W:1] : d_sum[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= '0;
      dead_q <= '0;
    end else begin
      live_q <= live_nx;
      dead_q <= dead_nx;
    end
  end

  // R7: a stored tally never sits at the saturation value
  assert_no_full_R7: assert property (@(posedge clk) disable iff (rst)
    (live_q != SAT) && (dead_q != SAT));

  // R7: a halving step never grows either tally
  assert_halve_shrinks_R7: assert property (@(posedge clk) disable iff (rst)
    sat |=> (live_q <= $past(live_q)) && (dead_q <= $past(dead_q)));

  // R2: a live strobe without saturation adds exactly one
  assert_live_step_R2: assert property (@(posedge clk) disable iff (rst)
    (live_inc && !sat) |=> live_q == CNT_W'($past(live_q) + 1'b1));

  // R3: a dead strobe without saturation adds exactly one
  assert_dead_step_R3: assert property (@(posedge clk) disable iff (rst)
    (dead_inc && !sat) |=> dead_q == CNT_W'($past(dead_q) + 1'b1));

  // R8: an untrained bin keeps its tallies
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!live_inc && !dead_inc) |=> $stable(live_q) && $stable(dead_q));
endmodule

// File: rtl/tuc_decision.sv
module tuc_decision
  import tuc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           req_valid,
  input  bin_t                           req_bin,
  input  logic [NUM_BINS-1:0][CNT_W-1:0] live_nx,
  input  logic [NUM_BINS-1:0][CNT_W-1:0] dead_nx,
  output logic                           dec_valid,
  output logic                           dec_bypass,
  output bin_t                           dec_bin
);
  logic [CNT_W-1:0] sel_live, sel_dead;

  always_comb begin
    sel_live = live_nx[req_bin];
    sel_dead = dead_nx[req_bin];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid  <= 1'b0;
      dec_bypass <= 1'b0;
      dec_bin    <= '0;
    end else begin
      dec_valid <= req_valid;
      if (req_valid) begin
        dec_bypass <= sel_dead > sel_live;
        dec_bin    <= req_bin;
      end
    end
  end

  // R5: a request is answered in the next cycle
  assert_answer_next_R5: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> dec_valid);

  // R5: no answer without a request
  assert_no_spurious_R5: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !dec_valid);

  // R1: the answer carries the requested bin
  assert_bin_echo_R1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> dec_bin == $past(req_bin));
endmodule

// File: rtl/tuc_bypass_predictor.sv
module tuc_bypass_predictor
  import tuc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [TRIP_W-1:0] req_trip,
  input  logic [USE_W-1:0] req_use,
  input  logic             live_valid,
  input  logic [BIN_W-1:0] live_bin,
  input  logic             dead_valid,
  input  logic [BIN_W-1:0] dead_bin,
  output logic             dec_valid,
  output logic             dec_bypass,
  output logic [BIN_W-1:0] dec_bin
);
  bin_t                           req_bin;
  logic [NUM_BINS-1:0]            live_sel, dead_sel;
  logic [NUM_BINS-1:0][CNT_W-1:0] live_nx, dead_nx, live_q, dead_q;

  assign req_bin = {req_trip, req_use};

  for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
    assign live_sel[b] = live_valid && (live_bin == BIN_W'(b));
    assign dead_sel[b] = dead_valid && (dead_bin == BIN_W'(b));

    tuc_bin_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .live_inc (live_sel[b]),
      .dead_inc (dead_sel[b]),
      .live_nx  (live_nx[b]),
      .dead_nx  (dead_nx[b]),
      .live_q   (live_q[b]),
      .dead_q   (dead_q[b])
    );
  end

  tuc_decision #(.CNT_W(CNT_W)) u_dec (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_bin    (req_bin),
    .live_nx    (live_nx),
    .dead_nx    (dead_nx),
    .dec_valid  (dec_valid),
    .dec_bypass (dec_bypass),
    .dec_bin    (dec_bin)
  );

  // R2/R3: training strobes reach only the addressed bin
  assert_strobe_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(live_sel) && $onehot0(dead_sel));

  // R9: tallies read zero right after reset
  assert_reset_clear_R9: assert property (@(posedge clk)
    $fell(rst) |-> (live_q == '0) && (dead_q == '0));
endmodule

// File: tb/test_tuc_bypass_predictor.sv
module test_tuc_bypass_predictor;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;
  localparam int SATV  = (1 << CNT_W) - 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_trip = 1'b0;
  logic [1:0] req_use = '0;
  logic       live_valid = 1'b0;
  logic [2:0] live_bin = '0;
  logic       dead_valid = 1'b0;
  logic [2:0] dead_bin = '0;
  logic       dec_valid, dec_bypass;
  logic [2:0] dec_bin;

  int compared = 0;
  int mismatched = 0;
  int live_m[8];
  int dead_m[8];
  int unsigned seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  tuc_bypass_predictor #(.CNT_W(CNT_W)) i_tuc_bypass_predictor (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_trip(req_trip),
    .req_use(req_use), .live_valid(live_valid), .live_bin(live_bin),
    .dead_valid(dead_valid), .dead_bin(dead_bin), .dec_valid(dec_valid),
    .dec_bypass(dec_bypass), .dec_bin(dec_bin)
  );

  function automatic void model_train(input logic lv, input logic [2:0] lb,
                                      input logic dv, input logic [2:0] db);
    if (lv) live_m[lb]++;
    if (dv) dead_m[db]++;
    for (int b = 0; b < 8; b++) begin
      if (live_m[b] >= SATV || dead_m[b] >= SATV) begin
        live_m[b] = live_m[b] / 2;
        dead_m[b] = dead_m[b] / 2;
      end
    end
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    for (int b = 0; b < 8; b++) begin live_m[b] = 0; dead_m[b] = 0; end
    repeat (2) @(negedge clk);
    compared++;
    if (dec_valid !== 1'b0) begin
      mismatched++;
      $display("FAIL R9 dec_valid in reset: got %b expected 0", dec_valid);
    end
    rst = 1'b0;
  endtask

  // called at a negedge; returns at the next negedge after checking
  task automatic step(input logic rq, input logic [2:0] rbin,
                      input logic lv, input logic [2:0] lb,
                      input logic dv, input logic [2:0] db, input string tag);
    logic exp_byp;
    req_valid = rq; req_trip = rbin[2]; req_use = rbin[1:0];
    live_valid = lv; live_bin = lb; dead_valid = dv; dead_bin = db;
    model_train(lv, lb, dv, db);
    exp_byp = dead_m[rbin] > live_m[rbin];
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; live_valid = 1'b0; dead_valid = 1'b0;
    compared++;
    if (dec_valid !== rq) begin
      mismatched++;
      $display("FAIL R5 %s dec_valid: got %b expected %b", tag, dec_valid, rq);
    end
    if (rq) begin
      compared++;
      if (dec_bypass !== exp_byp) begin
        mismatched++;
        $display("FAIL %s bin %0d dec_bypass: got %b expected %b (live %0d dead %0d)",
                 tag, rbin, dec_bypass, exp_byp, live_m[rbin], dead_m[rbin]);
      end
      compared++;
      if (dec_bin !== rbin) begin
        mismatched++;
        $display("FAIL R1 %s dec_bin: got %0d expected %0d", tag, dec_bin, rbin);
      end
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : stim
    @(negedge clk);
    do_reset();

    // R9 R4 R1: every bin allocates from the cleared state
    for (int b = 0; b < 8; b++) step(1'b1, 3'(b), 1'b0, 3'd0, 1'b0, 3'd0, "R9_R4_reset_alloc");

    // R3 R4: one dead allocation tips bin 3 to bypass
    step(1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 3'd3, "R3_train");
    step(1'b1, 3'd3, 1'b0, 3'd0, 1'b0, 3'd0, "R3_R4_bypass");
    // R2 R4: a live allocation restores the tie, which allocates
    step(1'b0, 3'd0, 1'b1, 3'd3, 1'b0, 3'd0, "R2_train");
    step(1'b1, 3'd3, 1'b0, 3'd0, 1'b0, 3'd0, "R2_R4_tie");

    // R6: a dead strobe in the request cycle already counts
    step(1'b1, 3'd5, 1'b0, 3'd0, 1'b1, 3'd5, "R6_same_cycle_dead");
    // R6: a live strobe in the request cycle restores the tie
    step(1'b1, 3'd5, 1'b1, 3'd5, 1'b0, 3'd0, "R6_same_cycle_live");

    // R7: drive bin 6 dead to saturation, then check the halved ratio
    for (int i = 0; i < SATV - 1; i++) step(1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 3'd6, "R7_fill");
    step(1'b1, 3'd6, 1'b0, 3'd0, 1'b0, 3'd0, "R7_before_halve");
    step(1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 3'd6, "R7_halve");
    for (int i = 0; i < SATV / 2 - 1; i++) step(1'b0, 3'd0, 1'b1, 3'd6, 1'b0, 3'd0, "R7_live_fill");
    step(1'b1, 3'd6, 1'b0, 3'd0, 1'b0, 3'd0, "R7_one_short_bypass");
    step(1'b1, 3'd6, 1'b1, 3'd6, 1'b0, 3'd0, "R7_halved_tie_alloc");
    // R8: bins 7 and 3 were left alone during that
    step(1'b1, 3'd7, 1'b0, 3'd0, 1'b0, 3'd0, "R8_neighbour");
    step(1'b1, 3'd3, 1'b0, 3'd0, 1'b0, 3'd0, "R8_neighbour");

    // R2 R3 R4 R8: pseudo-random sweep over all bins and strobe mixes
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] rb, lb, db;
      logic rq, lv, dv;
      seed = seed * 32'd1103515245 + 32'd12345;
      rq = seed[16]; rb = seed[19:17];
      lv = seed[20] & seed[21]; lb = seed[24:22];
      dv = seed[25] & seed[26]; db = seed[29:27];
      step(rq, rb, lv, lb, dv, db, "R2_R3_R4_R8_sweep");
    end

    // R9: a mid-run reset forgets every tally
    do_reset();
    for (int b = 0; b < 8; b++) step(1'b1, 3'(b), 1'b0, 3'd0, 1'b0, 3'd0, "R9_rereset_alloc");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule